// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Protocol Engine

This block is the byte-level protocol state machine for a two-wire serial EEPROM slave with 2048 bytes, seen as eight banks of 256 bytes. A separate bus condition detector turns the raw clock and data lines into single-cycle pulses: a start pulse, a stop pulse, a clock-rise pulse that comes with the sampled data level, and a clock-fall pulse. The engine counts bit slots from these pulses. It decodes the control byte and keeps an 11-bit address pointer. It sends received write data to a page buffer and reads stored bytes through a memory read port. It pulls the data line low through a single open-drain control, `sda_low`.

The top three address bits come from the bank-select field of the control byte, not from a device address. The low eight bits come from the word-address byte of a write command. Writes move the pointer inside a 16-byte page. Reads move it across the whole array. While the external write-cycle controller reports busy, the engine gives no acknowledge at all.

Write data leaves through a valid/ready stream. `pb_valid` rises one cycle after the eighth data bit is sampled. `pb_addr` and `pb_data` stay stable until `pb_ready` is seen. The beat must be taken before the clock-fall pulse that ends that eighth bit. If it is not taken, the byte is refused with a NACK and dropped, and the engine goes idle. `pb_ready` may be held low for as long as the buffer needs. The memory read port may have one cycle of latency.

Top module: `ee_slave_engine`

## Requirements
- R1: A control byte is received MSB first. It is acknowledged (`sda_low` high during the ninth slot) only when its bits 7:4 equal 1010. Any other code gets no acknowledge, and the engine drives nothing until the next START.
- R2: While `busy_i` is high, no control byte is acknowledged, even one with a matching code.
- R3: After a write control byte (bit 0 = 0), the next byte is acknowledged. The pointer then becomes {bank bits 3:1 of the control byte, that byte}.
- R4: Each write data byte raises `pb_valid` with `pb_addr` equal to the pointer and `pb_data` equal to the byte. The values stay stable until accepted. The byte is acknowledged only if it was accepted before the clock fall that ends its eighth bit. Otherwise it is NACKed, dropped and the pointer is left unchanged.
- R5: Each accepted write beat increments the low 4 pointer bits, wrapping within the 16-byte page. The upper 7 bits do not change.
- R6: In a read, the engine sends data MSB first, holding `sda_low` equal to the inverse of the bit during slots 0 to 7. It releases the line during the master's acknowledge slot.
- R7: A read control byte replaces the pointer's top three bits with its bank bits. It then returns the byte at the pointer. Every read or write access leaves the pointer one past the byte accessed.
- R8: A master acknowledge after a read byte makes the engine send the byte at the next address. The pointer increments over all 11 bits and wraps from 7FF to 000.
- R9: A master NACK after a read byte makes the engine release the line and stay silent until the next START.
- R10: A STOP after at least one accepted write beat gives exactly one `commit_p` pulse in the following cycle. A STOP with no accepted beat gives none.
- R11: After reset, `sda_low`, `pb_valid` and `commit_p` are low and the pointer (`rd_addr`) is 000.
- R12: A START at any point, including a repeated START, restarts control-byte reception at bit 0 while the pointer is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_p | input | 1 | START condition pulse |
| stop_p | input | 1 | STOP condition pulse |
| scl_rise_p | input | 1 | Clock rising-edge pulse; `sda_in` is sampled with it |
| scl_fall_p | input | 1 | Clock falling-edge pulse; ends the current bit slot |
| sda_in | input | 1 | Resolved data-line level |
| busy_i | input | 1 | Internal write cycle running |
| rd_data | input | 8 | Byte read from the array at `rd_addr` |
| pb_ready | input | 1 | Page buffer accepts the write beat |
| sda_low | output | 1 | Pull data line low |
| rd_addr | output | 11 | Current address pointer |
| pb_valid | output | 1 | Write beat offered |
| pb_addr | output | 11 | Array address of the write beat |
| pb_data | output | 8 | Data of the write beat |
| commit_p | output | 1 | Start the internal write cycle |

## Verification
A wrong slot count or a wrong state shows up in the next acknowledge slot: an acknowledge goes missing, or one appears where none should. A wrong pointer shows up only on the next read byte or write beat. For that reason every write is followed by a read-back through the normal read commands, and the bench predicts each beat address itself. Back-pressure faults show as an acknowledge on a dropped byte, or as a beat whose address moves while it waits. A commit fault is visible one cycle after STOP.

// File: rtl/ee_eng_pkg.sv
package ee_eng_pkg;
  localparam int BYTE_W = 8;
  localparam int SLOT_W = 4;
  localparam logic [SLOT_W-1:0] LAST_DATA_SLOT = 4'd7;
  localparam logic [SLOT_W-1:0] ACK_SLOT = 4'd8;
  localparam logic [3:0] CTRL_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } eng_state_e;
endpackage

// File: rtl/ee_bit_slot.sv
module ee_bit_slot
  import ee_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_p,
  input  logic              rise_p,
  input  logic              fall_p,
  input  logic              sda_in,
  output logic [SLOT_W-1:0] slot,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_done_q,
  output logic              byte_end,
  output logic              ack_end,
  output logic              mack
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot      <= '0;
      rx_byte   <= '0;
      rx_done_q <= 1'b0;
      mack      <= 1'b0;
    end else begin
      rx_done_q <= rise_p && (slot == LAST_DATA_SLOT) && !start_p;
      if (start_p)
        slot <= '0;
      else if (fall_p)
        slot <= (slot == ACK_SLOT) ? '0 : slot + 1'b1;
      if (rise_p && slot < ACK_SLOT)
        rx_byte <= {rx_byte[BYTE_W-2:0], sda_in};
      if (rise_p && slot == ACK_SLOT)
        mack <= ~sda_in;
    end
  end

  assign byte_end = fall_p && !start_p && (slot == LAST_DATA_SLOT);
  assign ack_end  = fall_p && !start_p && (slot == ACK_SLOT);

  AST_START_RESTARTS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (slot == '0)); // R12
  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= ACK_SLOT); // R12
endmodule

// File: rtl/ee_addr_ptr.sv
module ee_addr_ptr #(
  parameter int BLK_BITS  = 3,
  parameter int WORD_BITS = 8,
  parameter int PAGE_BITS = 4,
  localparam int AW = BLK_BITS + WORD_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_full,
  input  logic [AW-1:0]       load_val,
  input  logic                set_blk,
  input  logic [BLK_BITS-1:0] blk_val,
  input  logic                inc_read,
  input  logic                inc_page,
  output logic [AW-1:0]       ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= '0;
    else if (load_full)
      ptr <= load_val;
    else if (set_blk)
      ptr <= {blk_val, ptr[WORD_BITS-1:0]};
    else if (inc_read)
      ptr <= ptr + 1'b1;
    else if (inc_page)
      ptr <= {ptr[AW-1:PAGE_BITS], ptr[PAGE_BITS-1:0] + 1'b1};
  end

  AST_PAGE_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_page && !load_full && !set_blk && !inc_read)
      |=> ptr[AW-1:PAGE_BITS] == $past(ptr[AW-1:PAGE_BITS])); // R5
  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_read && !load_full && !set_blk) |=> ptr == $past(ptr) + AW'(1)); // R8
endmodule

// File: rtl/ee_slave_engine.sv
module ee_slave_engine
  import ee_eng_pkg::*;
#(
  parameter int BLK_BITS  = 3,
  parameter int WORD_BITS = 8,
  parameter int PAGE_BITS = 4,
  localparam int AW = BLK_BITS + WORD_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              scl_rise_p,
  input  logic              scl_fall_p,
  input  logic              sda_in,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic              pb_ready,
  output logic              sda_low,
  output logic [AW-1:0]     rd_addr,
  output logic              pb_valid,
  output logic [AW-1:0]     pb_addr,
  output logic [BYTE_W-1:0] pb_data,
  output logic              commit_p
);
  eng_state_e          state;
  logic [SLOT_W-1:0]   slot;
  logic [BYTE_W-1:0]   rx_byte;
  logic                rx_done_q, byte_end, ack_end, mack;
  logic [BLK_BITS-1:0] blk_q;
  logic                rw_q, acc_q, pend_q;
  logic [BYTE_W-2:0]   tx_q;
  logic [AW-1:0]       ptr;
  logic                code_ok, take_ctrl, beat_fire, acc_now;

  ee_bit_slot u_slot (
    .clk(clk), .rst_n(rst_n), .start_p(start_p), .rise_p(scl_rise_p),
    .fall_p(scl_fall_p), .sda_in(sda_in), .slot(slot), .rx_byte(rx_byte),
    .rx_done_q(rx_done_q), .byte_end(byte_end), .ack_end(ack_end), .mack(mack)
  );

  assign code_ok   = (rx_byte[BYTE_W-1:BYTE_W-4] == CTRL_CODE);
  assign take_ctrl = byte_end && (state == ST_CTRL) && code_ok && !busy_i;
  assign beat_fire = pb_valid && pb_ready;
  assign acc_now   = acc_q || beat_fire;

  ee_addr_ptr #(.BLK_BITS(BLK_BITS), .WORD_BITS(WORD_BITS), .PAGE_BITS(PAGE_BITS)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load_full(byte_end && state == ST_ADDR && !stop_p),
    .load_val({blk_q, rx_byte}),
    .set_blk(take_ctrl && rx_byte[0] && !stop_p),
    .blk_val(rx_byte[BLK_BITS:1]),
    .inc_read(byte_end && state == ST_RDATA && !stop_p),
    .inc_page(beat_fire),
    .ptr(ptr)
  );

  assign rd_addr = ptr;
  assign pb_addr = ptr;
  assign pb_data = rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sda_low  <= 1'b0;
      pb_valid <= 1'b0;
      acc_q    <= 1'b0;
      pend_q   <= 1'b0;
      commit_p <= 1'b0;
      blk_q    <= '0;
      rw_q     <= 1'b0;
      tx_q     <= '0;
    end else begin
      commit_p <= 1'b0;
      if (beat_fire) begin
        pb_valid <= 1'b0;
        acc_q    <= 1'b1;
        pend_q   <= 1'b1;
      end
      if (rx_done_q && state == ST_WDATA) begin
        pb_valid <= 1'b1;
        acc_q    <= 1'b0;
      end
      if (stop_p) begin
        state    <= ST_IDLE;
        sda_low  <= 1'b0;
        pb_valid <= 1'b0;
        commit_p <= pend_q || beat_fire;
        pend_q   <= 1'b0;
      end else if (start_p) begin
        state    <= ST_CTRL;
        sda_low  <= 1'b0;
        pb_valid <= 1'b0;
      end else if (byte_end) begin
        unique case (state)
          ST_CTRL: begin
            if (take_ctrl) begin
              sda_low <= 1'b1;
              rw_q    <= rx_byte[0];
              blk_q   <= rx_byte[BLK_BITS:1];
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_ADDR: sda_low <= 1'b1;
          ST_WDATA: begin
            if (acc_now) begin
              sda_low <= 1'b1;
            end else begin
              state    <= ST_IDLE;
              pb_valid <= 1'b0;
            end
          end
          ST_RDATA: sda_low <= 1'b0;
          default: sda_low <= 1'b0;
        endcase
      end else if (ack_end) begin
        unique case (state)
          ST_CTRL: begin
            if (rw_q) begin
              state   <= ST_RDATA;
              sda_low <= ~rd_data[BYTE_W-1];
              tx_q    <= rd_data[BYTE_W-2:0];
            end else begin
              state   <= ST_ADDR;
              sda_low <= 1'b0;
            end
          end
          ST_ADDR: begin
            state   <= ST_WDATA;
            sda_low <= 1'b0;
          end
          ST_RDATA: begin
            if (mack) begin
              sda_low <= ~rd_data[BYTE_W-1];
              tx_q    <= rd_data[BYTE_W-2:0];
            end else begin
              state   <= ST_IDLE;
              sda_low <= 1'b0;
            end
          end
          default: sda_low <= 1'b0;
        endcase
      end else if (scl_fall_p && state == ST_RDATA && slot < LAST_DATA_SLOT) begin
        sda_low <= ~tx_q[BYTE_W-2];
        tx_q    <= {tx_q[BYTE_W-3:0], 1'b0};
      end
    end
  end

  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && state == ST_CTRL && busy_i && !start_p && !stop_p) |=> !sda_low); // R2
  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_valid && !pb_ready && !stop_p && !start_p && !byte_end)
      |=> pb_valid && $stable(pb_data) && $stable(pb_addr)); // R4
  AST_NACK_DROPS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && state == ST_WDATA && !acc_now && !stop_p && !start_p) |=> !pb_valid && !sda_low); // R4
  AST_COMMIT_FOLLOWS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    commit_p |-> $past(stop_p)); // R10
  AST_MASTER_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RDATA && slot == ACK_SLOT) |-> !sda_low); // R6
endmodule

// File: tb/ee_slave_engine_tb.sv
module ee_slave_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_p = 0, stop_p = 0, scl_rise_p = 0, scl_fall_p = 0;
  logic m_sda = 1'b1, busy_i = 1'b0, pb_ready = 1'b0;
  logic [7:0] rd_data;
  logic sda_low, pb_valid, commit_p;
  logic [10:0] rd_addr, pb_addr;
  logic [7:0] pb_data;
  logic sda_in;

  int checks = 0, errors = 0, commits = 0, nacc = 0, rdy_mode = 1, vcnt = 0;
  logic [7:0]  mem [0:2047];
  logic [10:0] acc_addr [0:63];
  logic [7:0]  acc_data [0:63];
  logic [10:0] exp_ptr = '0;

  always #5 clk = ~clk;
  assign sda_in = m_sda & ~sda_low;

  ee_slave_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start_p(start_p), .stop_p(stop_p),
    .scl_rise_p(scl_rise_p), .scl_fall_p(scl_fall_p), .sda_in(sda_in),
    .busy_i(busy_i), .rd_data(rd_data), .pb_ready(pb_ready), .sda_low(sda_low),
    .rd_addr(rd_addr), .pb_valid(pb_valid), .pb_addr(pb_addr), .pb_data(pb_data),
    .commit_p(commit_p)
  );

  always @(posedge clk) begin
    rd_data <= mem[rd_addr];
    if (commit_p) commits++;
    if (pb_valid && pb_ready) begin
      mem[pb_addr] <= pb_data;
      if (nacc < 64) begin acc_addr[nacc] = pb_addr; acc_data[nacc] = pb_data; end
      nacc++;
    end
  end

  always @(negedge clk) begin
    if (pb_valid) vcnt++; else vcnt = 0;
    pb_ready = (rdy_mode == 1) || (rdy_mode == 2 && vcnt >= 2);
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_p = 1; @(negedge clk) start_p = 0; repeat (2) @(negedge clk);
  endtask
  task automatic pulse_stop();
    @(negedge clk) stop_p = 1; @(negedge clk) stop_p = 0; repeat (2) @(negedge clk);
  endtask

  task automatic bit_slot(input logic m, output logic seen);
    @(negedge clk) m_sda = m;
    repeat (2) @(negedge clk);
    seen = sda_in; scl_rise_p = 1;
    @(negedge clk) scl_rise_p = 0;
    repeat (2) @(negedge clk);
    scl_fall_p = 1;
    @(negedge clk) scl_fall_p = 0;
    m_sda = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_slot(b[i], s);
    bit_slot(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b, output logic released);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_slot(1'b1, s); b[i] = s; end
    bit_slot(!give_ack, s);
    released = s;
  endtask

  task automatic do_write(input logic [10:0] a, input int n);
    logic ack; logic [7:0] d; int c0;
    nacc = 0; c0 = commits;
    pulse_start();
    send_byte({4'hA, a[10:8], 1'b0}, ack); check(ack, "R1 write control ack", ack, 1);
    send_byte(a[7:0], ack);                check(ack, "R3 word address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      logic [10:0] ea;
      d = 8'($urandom);
      ea = {a[10:4], 4'(a[3:0] + k)};
      send_byte(d, ack);
      check(ack, "R4 data ack", ack, 1);
      check(nacc == k + 1 && acc_addr[k] == ea, "R5 beat address", acc_addr[k], ea);
      check(acc_data[k] == d, "R4 beat data", acc_data[k], d);
    end
    pulse_stop();
    check(commits == c0 + 1, "R10 one commit", commits - c0, 1);
    exp_ptr = {a[10:4], 4'(a[3:0] + n)};
  endtask

  task automatic do_read_at(input logic [10:0] a, input int n);
    logic ack, rel; logic [7:0] b; int c0;
    c0 = commits;
    pulse_start();
    send_byte({4'hA, a[10:8], 1'b0}, ack); check(ack, "R1 control ack", ack, 1);
    send_byte(a[7:0], ack);                check(ack, "R3 address ack", ack, 1);
    pulse_start();
    send_byte({4'hA, a[10:8], 1'b1}, ack); check(ack, "R12 repeated start read ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      logic [10:0] ea;
      ea = 11'(a + k);
      recv_byte(k < n - 1, b, rel);
      check(b == mem[ea], "R8 sequential data", b, mem[ea]);
      if (k == n - 1) check(rel, "R9 released after master NACK", rel, 1);
    end
    pulse_stop();
    check(commits == c0, "R10 no commit on read", commits - c0, 0);
    exp_ptr = 11'(a + n);
  endtask

  task automatic cur_read();
    logic ack, rel; logic [7:0] b;
    pulse_start();
    send_byte({4'hA, exp_ptr[10:8], 1'b1}, ack); check(ack, "R7 read control ack", ack, 1);
    recv_byte(1'b0, b, rel);
    check(b == mem[exp_ptr], "R7 current address data", b, mem[exp_ptr]);
    check(rel, "R6 line released in master slot", rel, 1);
    pulse_stop();
    exp_ptr = 11'(exp_ptr + 1);
  endtask

  initial begin
    logic ack, rel; logic [7:0] b; int c0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 2048; i++) mem[i] = 8'(i * 29 + (i >> 8) * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!sda_low && !pb_valid && !commit_p, "R11 reset outputs", {sda_low, pb_valid, commit_p}, 0);
    check(rd_addr == 0, "R11 reset pointer", rd_addr, 0);

    do_write(11'h2A5, 1);
    cur_read();
    do_write(11'h13E, 18);
    cur_read();
    do_read_at(11'h7FE, 4);
    cur_read();

    pulse_start();
    send_byte(8'h5A, ack); check(!ack, "R1 wrong code no ack", ack, 0);
    send_byte(8'hA0, ack); check(!ack, "R1 silent until START", ack, 0);
    recv_byte(1'b0, b, rel); check(b == 8'hFF, "R9 idle drives nothing", b, 8'hFF);
    pulse_stop();

    busy_i = 1'b1;
    pulse_start();
    send_byte(8'hA0, ack); check(!ack, "R2 busy no ack", ack, 0);
    pulse_stop();
    busy_i = 1'b0;

    rdy_mode = 0; nacc = 0; c0 = commits;
    pulse_start();
    send_byte(8'hA6, ack); check(ack, "R1 ack", ack, 1);
    send_byte(8'h47, ack); check(ack, "R3 ack", ack, 1);
    send_byte(8'h99, ack); check(!ack, "R4 refused beat NACK", ack, 0);
    check(nacc == 0, "R4 no beat taken", nacc, 0);
    pulse_stop();
    check(commits == c0, "R10 no commit without beat", commits - c0, 0);
    exp_ptr = 11'h347;
    cur_read();
    rdy_mode = 2;
    do_write(11'h0FD, 3);
    cur_read();
    rdy_mode = 1;

    for (int it = 0; it < 12; it++) begin
      logic [10:0] a; int n;
      a = 11'($urandom);
      n = 1 + int'($urandom % 5);
      do_write(a, n);
      cur_read();
      do_read_at({a[10:4], 4'h0}, 16);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule